// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block sequences the signal lamps at a crossing of two roads. Each road has a vehicle sensor. The controller keeps a road on green for as long as its sensor reports waiting or passing traffic. When that traffic clears, the road goes to yellow for one cycle. Both roads then show red for one cycle, and only after that does the other road get green. The same cycle runs on both sides, so each road's green lasts as long as its sensor keeps it.

It is a Moore machine with a three-bit phase register and six legal phases. Both lamp outputs are decoded from the registered phase alone, so the sensors affect the lamps only through the next clock edge. The reset is synchronous and active low, and it puts road A on green. An unused phase code falls back to road A green on the next edge.

Top module: `crossing_light_ctrl`

## Requirements
- R1: When rst_n is low at a rising clock edge, the phase after that edge shows lamp_a green (2'b00) and lamp_b red (2'b10), whatever the sensors are doing.
- R2: While lamp_a is green and road_a_busy is 1 at an edge, lamp_a stays green after the edge. road_b_busy has no effect in this phase.
- R3: While lamp_a is green and road_a_busy is 0 at an edge, the next phase shows lamp_a yellow (2'b01) and lamp_b red.
- R4: After a road A yellow phase come exactly one all-red phase and then lamp_b green with lamp_a red. Neither sensor changes this order.
- R5: While lamp_b is green and road_b_busy is 1 at an edge, lamp_b stays green after the edge. road_a_busy has no effect in this phase.
- R6: While lamp_b is green and road_b_busy is 0 at an edge, the next phases are lamp_b yellow, then one all-red phase, then lamp_a green with lamp_b red.
- R7: Each lamp output only ever carries green 2'b00, yellow 2'b01 or red 2'b10, and never 2'b11.
- R8: In no cycle do both lamps show something other than red.
- R9: The lamp outputs change only after a rising clock edge. A change on a sensor between edges leaves them as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| road_a_busy | input | 1 | Traffic sensor on road A, 1 = traffic present |
| road_b_busy | input | 1 | Traffic sensor on road B, 1 = traffic present |
| lamp_a | output | 2 | Road A lamp: 00 green, 01 yellow, 10 red |
| lamp_b | output | 2 | Road B lamp: 00 green, 01 yellow, 10 red |

## Verification
The bench goes after the phases where the sensor of the road that is not green changes, to show it is ignored. A design that looked at the wrong sensor would leave green early or stay on it too long. It drives long sensor-high stretches followed by a single low cycle. A design that skipped the clearance phase would jump straight from yellow to the crossing road's green and break the mutual-exclusion check. It also asserts reset in the middle of yellow and all-red phases, where a machine that ignored reset would go on with its sequence. Sensor toggles placed between edges catch any lamp path that bypasses the phase register.

// File: rtl/crossing_light_pkg.sv
// Package: shared phase and lamp encodings for the crossing light controller.
// Assumes: the phase code bits are decoded by the lamp decoders, so values are fixed.
package crossing_light_pkg;

    localparam int PHASE_W = 3;
    localparam int LAMP_W  = 2;
    localparam int ROADS   = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO    = 3'b000,
        PH_A_WARN  = 3'b001,
        PH_CLR_AB  = 3'b010,
        PH_B_GO    = 3'b100,
        PH_B_WARN  = 3'b101,
        PH_CLR_BA  = 3'b110
    } phase_e;

    typedef enum logic [LAMP_W-1:0] {
        LAMP_GO   = 2'b00,
        LAMP_WARN = 2'b01,
        LAMP_STOP = 2'b10
    } lamp_e;

endpackage

// File: rtl/crossing_next_phase.sv
// Module: combinational next-phase logic.
// Holds a green phase while its own road's sensor is high and steps through
// the warn and clearance phases one cycle each. Any code outside the legal
// six returns to road A green. Assumes sensors are already synchronous.
module crossing_next_phase
    import crossing_light_pkg::*;
(
    input  phase_e cur_phase,
    input  logic   a_busy,
    input  logic   b_busy,
    output phase_e nxt_phase
);

    // Purpose: pick the phase for the next edge.
    always_comb begin
        unique case (cur_phase)
            PH_A_GO:   nxt_phase = a_busy ? PH_A_GO : PH_A_WARN;
            PH_A_WARN: nxt_phase = PH_CLR_AB;
            PH_CLR_AB: nxt_phase = PH_B_GO;
            PH_B_GO:   nxt_phase = b_busy ? PH_B_GO : PH_B_WARN;
            PH_B_WARN: nxt_phase = PH_CLR_BA;
            PH_CLR_BA: nxt_phase = PH_A_GO;
            default:   nxt_phase = PH_A_GO;
        endcase
    end

endmodule

// File: rtl/crossing_phase_reg.sv
// Module: phase register with synchronous active-low reset.
// Assumes the reset value is the road A green phase.
module crossing_phase_reg
    import crossing_light_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e nxt_phase,
    output phase_e cur_phase
);

    // Purpose: capture the next phase, or force A green under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_phase <= PH_A_GO;
        else        cur_phase <= nxt_phase;
    end

endmodule

// File: rtl/crossing_lamp_decode.sv
// Module: lamp decoder for one road.
// ROAD_SEL selects which road this copy serves: 0 for road A, 1 for road B.
// Phase bit 2 names the road that owns the go/warn phases, and bits 1:0 name
// go (00), warn (01) or clearance (10). Assumes a legal phase code.
module crossing_lamp_decode
    import crossing_light_pkg::*;
#(
    parameter bit ROAD_SEL = 1'b0
) (
    input  phase_e            cur_phase,
    output logic [LAMP_W-1:0] lamp
);

    localparam logic [PHASE_W-1:0] GO_CODE   = {ROAD_SEL, 2'b00};
    localparam logic [PHASE_W-1:0] WARN_CODE = {ROAD_SEL, 2'b01};

    // Purpose: green or yellow only in this road's own phases, red otherwise.
    always_comb begin
        if (cur_phase == GO_CODE)        lamp = LAMP_GO;
        else if (cur_phase == WARN_CODE) lamp = LAMP_WARN;
        else                             lamp = LAMP_STOP;
    end

endmodule

// File: rtl/crossing_light_ctrl.sv
// Module: top of the two-road crossing light controller.
// Moore machine: lamps come from the registered phase only. Reset is
// synchronous, active low, and selects road A green.
module crossing_light_ctrl
    import crossing_light_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              road_a_busy,
    input  logic              road_b_busy,
    output logic [LAMP_W-1:0] lamp_a,
    output logic [LAMP_W-1:0] lamp_b
);

    phase_e            phase_q;
    phase_e            phase_d;
    logic [LAMP_W-1:0] lamps [ROADS];

    crossing_next_phase u_next (
        .cur_phase (phase_q),
        .a_busy    (road_a_busy),
        .b_busy    (road_b_busy),
        .nxt_phase (phase_d)
    );

    crossing_phase_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_phase (phase_d),
        .cur_phase (phase_q)
    );

    for (genvar r = 0; r < ROADS; r++) begin : g_road
        crossing_lamp_decode #(.ROAD_SEL(r[0])) u_dec (
            .cur_phase (phase_q),
            .lamp      (lamps[r])
        );
    end

    assign lamp_a = lamps[0];
    assign lamp_b = lamps[1];

endmodule

// File: rtl/crossing_light_chk.sv
// Checker: port-level properties of the crossing light controller.
module crossing_light_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       road_a_busy,
    input logic       road_b_busy,
    input logic [1:0] lamp_a,
    input logic [1:0] lamp_b
);

    localparam logic [1:0] G = 2'b00;
    localparam logic [1:0] Y = 2'b01;
    localparam logic [1:0] R = 2'b10;

    AST_A_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (lamp_a == G && road_a_busy) |=> lamp_a == G); // R2
    AST_A_LEAVE:  assert property (@(posedge clk) disable iff (!rst_n) (lamp_a == G && !road_a_busy) |=> (lamp_a == Y && lamp_b == R)); // R3
    AST_A_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n) lamp_a == Y |=> (lamp_a == R && lamp_b == R)); // R4
    AST_A_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n) lamp_a == Y |-> ##2 (lamp_b == G && lamp_a == R)); // R4
    AST_B_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (lamp_b == G && road_b_busy) |=> lamp_b == G); // R5
    AST_B_LEAVE:  assert property (@(posedge clk) disable iff (!rst_n) (lamp_b == G && !road_b_busy) |=> (lamp_b == Y && lamp_a == R)); // R6
    AST_B_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n) lamp_b == Y |-> ##2 (lamp_a == G && lamp_b == R)); // R6
    AST_LEGAL_CODES: assert property (@(posedge clk) disable iff (!rst_n) (lamp_a != 2'b11 && lamp_b != 2'b11)); // R7
    AST_ONE_ROAD: assert property (@(posedge clk) disable iff (!rst_n) (lamp_a == R || lamp_b == R)); // R8

endmodule

bind crossing_light_ctrl crossing_light_chk u_chk (.*);

// File: tb/sim_crossing_light_ctrl.sv
// Bench: seeded random sensor traffic plus directed corner cases.
module sim_crossing_light_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_busy = 1'b0;
    logic       b_busy = 1'b0;
    logic [1:0] lamp_a;
    logic [1:0] lamp_b;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit model_ok = 1'b0;

    crossing_light_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .road_a_busy (a_busy),
        .road_b_busy (b_busy),
        .lamp_a      (lamp_a),
        .lamp_b      (lamp_b)
    );

    always #10 clk = ~clk;

    function automatic int next_of(int st, bit a, bit b);
        case (st)
            0: return a ? 0 : 1;
            1: return 2;
            2: return 3;
            3: return b ? 3 : 4;
            4: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] exp_a(int st);
        return (st == 0) ? 2'b00 : (st == 1) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] exp_b(int st);
        return (st == 3) ? 2'b00 : (st == 4) ? 2'b01 : 2'b10;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s lamps actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check mid-cycle, check after the edge.
    task automatic step(bit r, bit a, bit b);
        string tag;
        rst_n = r; a_busy = a; b_busy = b;
        #3;
        if (model_ok) check("R9", {lamp_a, lamp_b}, {exp_a(model), exp_b(model)});
        @(posedge clk);
        if (!r)                        tag = "R1";
        else if (model == 0)           tag = a ? "R2" : "R3";
        else if (model == 1 || model == 2) tag = "R4";
        else if (model == 3)           tag = b ? "R5" : "R6";
        else                           tag = "R6";
        model = r ? next_of(model, a, b) : 0;
        model_ok = 1'b1;
        @(negedge clk);
        check(tag, {lamp_a, lamp_b}, {exp_a(model), exp_b(model)});
        checks++;
        if (lamp_a == 2'b11 || lamp_b == 2'b11) begin
            failures++;
            $display("FAIL R7 lamps actual=%b%b expected=no 11 code", lamp_a, lamp_b);
        end
        checks++;
        if (lamp_a != 2'b10 && lamp_b != 2'b10) begin
            failures++;
            $display("FAIL R8 lamps actual=%b%b expected=one road red", lamp_a, lamp_b);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        step(0, 1, 1);
        step(0, 0, 0);
        // R2: A held by its sensor, B sensor ignored
        for (int i = 0; i < 6; i++) step(1, 1, i[0]);
        // R3, R4: A clears, crossing order fixed regardless of sensors
        step(1, 0, 0);
        step(1, 1, 1);
        step(1, 1, 0);
        // R5: B held, A sensor toggling
        for (int i = 0; i < 6; i++) step(1, i[0], 1);
        // R6: B clears and hands back
        step(1, 1, 0);
        step(1, 0, 1);
        step(1, 1, 1);
        step(1, 1, 1);
        // R1: reset during A yellow and during clearance
        step(1, 0, 0);
        step(0, 1, 1);
        step(1, 0, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        // random traffic with rare resets
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 40) != 0, ($urandom % 4) != 0, ($urandom % 3) != 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule